// File: doc/BRIEF.md
# Two-Key Sequence Lock

This block is a small synchronous state machine that watches a two-bit key input once per clock and raises a single unlock output only after the exact sampled sequence 00, 01, 01, 10 has arrived on consecutive clock edges. Because every clock edge takes a fresh sample, a key value held for two periods counts as two steps. The repeated 01 in the middle of the code therefore has to be held for exactly two edges, not one and not three.

Any sample that does not continue the sequence throws the attempt away. A breaking sample of 00 is kept as the first step of a new attempt. Any other breaking sample sends the machine to idle. The key bits are assumed to be already synchronous to the clock.

A parameter picks the output style. The default is registered (Moore): the output is high for the one period spent in the open state. The other variant (Mealy) raises the output combinationally while the machine is at the last step and the key reads 10. That is one period earlier, and the output lasts only as long as that input.

Top module: `keyseq_lock`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in idle at the next rising edge, whatever `key` holds. In the Moore variant `unlock` is then low.
- R2: `key[1]` is the first key and `key[0]` is the second. The sequence `key` = 2'b00, 2'b01, 2'b01, 2'b10 on four consecutive edges enters the open state. With `MEALY`=0, `unlock` is high for exactly the one period after the edge that samples 2'b10.
- R3: A sequence with a third 01 (00, 01, 01, 01, 10) does not raise `unlock`.
- R4: A sample of 2'b00 in any state takes the machine to step one. For example, 00, 01, 00, 01, 01, 10 unlocks.
- R5: Any other sample that breaks the sequence returns the machine to idle. For example, 00, 01, 11, 01, 01, 10 does not unlock.
- R6: From the open state, a following 00 counts as step one, so back-to-back codes unlock twice. Any other value goes to idle.
- R7: With `MEALY`=1, `unlock` is high exactly while the machine is at step three and `key` is 2'b10. The state transitions are the same as in the Moore variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| key | input | 2 | Sampled key pair, first key in bit 1 |
| unlock | output | 1 | Open indication (registered or combinational per `MEALY`) |

## Verification
A wrong step in the internal state cannot stay hidden for long. Within at most four edges it either raises `unlock` after a sequence that should be rejected, or keeps `unlock` low one period after a correct final 10. The bench runs a model of the step count alongside the design and compares `unlock` every period, for both output variants. Random key streams are biased toward the correct code, so restarts, repeats and back-to-back codes are hit often.

// File: rtl/keyseq_lock.sv
module keyseq_lock #(
  parameter bit MEALY = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] key,
  output logic       unlock
);
  localparam logic [2:0] IDLE  = 3'b000;
  localparam logic [2:0] STEP1 = 3'b001;
  localparam logic [2:0] STEP2 = 3'b011;
  localparam logic [2:0] STEP3 = 3'b010;
  localparam logic [2:0] OPEN  = 3'b100;

  logic [2:0] state, nxt;

  always_comb begin
    nxt = IDLE;
    if (key == 2'b00) nxt = STEP1;
    else begin
      case (state)
        STEP1:   if (key == 2'b01) nxt = STEP2;
        STEP2:   if (key == 2'b01) nxt = STEP3;
        STEP3:   if (key == 2'b10) nxt = OPEN;
        default: nxt = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= IDLE;
    else     state <= nxt;
  end

  generate
    if (MEALY) begin : g_mealy
      assign unlock = (state == STEP3) && (key == 2'b10);
    end else begin : g_moore
      assign unlock = state[2];
    end
  endgenerate
endmodule

module keyseq_lock_chk #(
  parameter bit MEALY = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] key,
  input logic       unlock,
  input logic [2:0] state
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> state == 3'b000); // R1
  AST_OPEN_AFTER_CODE: assert property (@(posedge clk) disable iff (rst)
    (state == 3'b010 && key == 2'b10) |=> state == 3'b100); // R2
  AST_OPEN_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    state == 3'b100 |=> state != 3'b100); // R2
  AST_ZERO_RESTART: assert property (@(posedge clk) disable iff (rst)
    key == 2'b00 |=> state == 3'b001); // R4
  AST_BAD_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    key == 2'b11 |=> state == 3'b000); // R5
  AST_MOORE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!MEALY && unlock) |-> ($past(key) == 2'b10 && !$past(rst))); // R2
  AST_MEALY_LEADS: assert property (@(posedge clk) disable iff (rst)
    (MEALY && unlock) |=> state == 3'b100); // R7
endmodule

bind keyseq_lock keyseq_lock_chk #(.MEALY(MEALY)) u_chk (
  .clk(clk), .rst(rst), .key(key), .unlock(unlock), .state(state)
);

// File: tb/sim_keyseq_lock.sv
`timescale 1ns/1ps
module sim_keyseq_lock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] key = 2'b00;
  logic unlock_moore, unlock_mealy;
  int checks = 0;
  int errors = 0;
  int m = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyseq_lock #(.MEALY(1'b0)) u0 (.clk(clk), .rst(rst), .key(key), .unlock(unlock_moore));
  keyseq_lock #(.MEALY(1'b1)) u1 (.clk(clk), .rst(rst), .key(key), .unlock(unlock_mealy));

  function automatic int next_step(int s, bit r, logic [1:0] k);
    if (r) return 0;
    if (k == 2'b00) return 1;
    if (k == 2'b01 && s == 1) return 2;
    if (k == 2'b01 && s == 2) return 3;
    if (k == 2'b10 && s == 3) return 4;
    return 0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: unlock=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit r, logic [1:0] k);
    @(negedge clk);
    rst = r;
    key = k;
    #1;
    check({tag, " mealy R7"}, unlock_mealy, (m == 3 && k == 2'b10));
    @(posedge clk);
    m = next_step(m, r, k);
    #1;
    check(tag, unlock_moore, (m == 4));
  endtask

  task automatic run(string tag, logic [1:0] seq[$]);
    foreach (seq[i]) step(tag, 1'b0, seq[i]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [1:0] code[4] = '{2'b00, 2'b01, 2'b01, 2'b10};
    void'($urandom(32'd24681));
    step("R1 reset", 1'b1, 2'b11);
    step("R1 reset", 1'b1, 2'b00);
    run("R2 code", '{2'b11, 2'b00, 2'b01, 2'b01, 2'b10, 2'b11, 2'b11});
    run("R3 repeat", '{2'b00, 2'b01, 2'b01, 2'b01, 2'b10, 2'b11});
    run("R4 restart", '{2'b00, 2'b01, 2'b00, 2'b01, 2'b01, 2'b10, 2'b11});
    run("R5 break", '{2'b00, 2'b01, 2'b11, 2'b01, 2'b01, 2'b10, 2'b11});
    run("R6 back2back", '{2'b00, 2'b01, 2'b01, 2'b10, 2'b00, 2'b01, 2'b01, 2'b10, 2'b01});
    run("R6 open_exit", '{2'b01, 2'b01, 2'b10, 2'b11});
    run("R1 prep", '{2'b00, 2'b01, 2'b01});
    step("R1 priority", 1'b1, 2'b10);
    step("R1 priority", 1'b0, 2'b11);
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] k;
      if ($urandom % 8 < 5) k = code[(m >= 1 && m <= 3) ? m : 0];
      else k = 2'($urandom);
      step("R2 random", ($urandom % 64) == 0, k);
    end
    finish_run();
  end
endmodule